// File: doc/BRIEF.md
# Johnson Decade Counter With Decoded Outputs

This block counts events on a slow count-clock input through ten states and raises exactly one of ten decoded outputs for the current count. The count is held in a twisted-ring (Johnson) register of `STAGES` bits, which gives `2*STAGES` states. Every decoded output is an AND of just two neighbouring ring bits. A carry output forms a square wave at one tenth of the count rate, so that a further counter can be chained onto it.

All logic runs on one fast system clock. The count clock and the active-high inhibit are sampled as ordinary synchronous inputs, and their edges are found inside the block. The count can advance in two ways: a rising count-clock edge while inhibit is low, or a falling inhibit edge while the count clock is high. When the ring holds a pattern that is not one of the valid codes, a forced shift-in value steers it back into the valid sequence within a few advances. The active-high reset is synchronous and clears the count.

Top module: `johnson_decade`

## Requirements
- R1: While `rst` is high at a system clock edge, the count goes to zero (`dec_o` = one-hot bit 0, `carry_o` = 1). Reset takes priority over any count-clock or inhibit activity.
- R2: A rising edge of `cnt_clk` while `cnt_inh` is low advances the count by exactly one state. The input is registered on the first system edge after it changes, and the decoded outputs change on the second system edge.
- R3: While `cnt_inh` is high, rising edges of `cnt_clk` leave the count unchanged.
- R4: A falling edge of `cnt_inh` while `cnt_clk` is high advances the count by one state.
- R5: A falling edge of `cnt_clk`, a rising edge of `cnt_inh`, and a falling edge of `cnt_inh` while `cnt_clk` is low all leave the count unchanged.
- R6: The ring codes for counts 0 to 9 are 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000. Each advance shifts the ring one place towards the MSB and shifts in the inverse of the old MSB. For count k, `dec_o[k]` is the only high bit. Each output comes from two ring bits, and for a valid code exactly one output is high.
- R7: `carry_o` is high during counts 0 to `STAGES-1` (0 to 4) and low during counts `STAGES` to `2*STAGES-1` (5 to 9). It therefore rises when the count wraps to zero.
- R8: When the ring holds any of the 22 five-bit codes outside the valid ten, each advance shifts in 0. The ring reaches a valid code within `STAGES-1` (4) advances and then counts normally.
- R9: Input levels that change while `rst` is high are taken as the new resting levels. After `rst` falls, no advance happens until a new qualifying edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to count zero |
| cnt_clk | input | 1 | Count clock, sampled on `clk` |
| cnt_inh | input | 1 | Active-high count inhibit, also a falling-edge count input while `cnt_clk` is high |
| dec_o | output | 2*STAGES (10) | One-hot decoded count |
| carry_o | output | 1 | Carry: high for the lower half of the count range |

## Verification
The bench builds the counter with the default `STAGES` of 5. With this value all 32 ring patterns can be enumerated, so every one of the 22 invalid codes is deposited into the ring and its return to the sequence is followed advance by advance. The ten-state wrap, and the carry toggling at the 4-to-5 and 9-to-0 boundaries, are crossed more than once within a short run.

// File: rtl/jdc_pkg.sv
`timescale 1ns/1ps
package jdc_pkg;

    localparam int unsigned DEF_STAGES = 5;

    // One registered sample of the two count-side inputs
    typedef struct packed {
        logic cclk;
        logic cinh;
    } pin_smp_t;

    // Which qualifying edge (if any) was seen in this cycle
    typedef enum logic [1:0] {
        SRC_NONE     = 2'b00,
        SRC_CLK_RISE = 2'b01,
        SRC_INH_FALL = 2'b10,
        SRC_BOTH     = 2'b11
    } adv_src_e;

    // Rise of the count clock counts only with inhibit low;
    // fall of inhibit counts only with the count clock high.
    function automatic adv_src_e classify(pin_smp_t cur, pin_smp_t prv);
        logic rise_ok;
        logic fall_ok;
        rise_ok = cur.cclk & ~prv.cclk & ~cur.cinh;
        fall_ok = prv.cinh & ~cur.cinh & cur.cclk;
        return adv_src_e'({fall_ok, rise_ok});
    endfunction

    function automatic logic src_advances(adv_src_e src);
        return src != SRC_NONE;
    endfunction

endpackage

// File: rtl/jdc_edge_sense.sv
`timescale 1ns/1ps
module jdc_edge_sense
    import jdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cnt_clk,
    input  logic cnt_inh,
    output logic adv
);

    pin_smp_t pin_now;
    pin_smp_t smp_q;
    pin_smp_t prv_q;
    adv_src_e src;

    assign pin_now = '{cclk: cnt_clk, cinh: cnt_inh};

    // During reset both stages take the live level, so nothing held
    // across reset release looks like an edge (R9).
    always_ff @(posedge clk) begin
        smp_q <= pin_now;
        if (rst) begin
            prv_q <= pin_now;
        end else begin
            prv_q <= smp_q;
        end
    end

    assign src = classify(smp_q, prv_q);
    assign adv = src_advances(src);

endmodule

// File: rtl/jdc_ring.sv
`timescale 1ns/1ps
module jdc_ring #(
    parameter int unsigned STAGES = jdc_pkg::DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [STAGES-1:0] ring_o,
    output logic              legal_o
);

    localparam int unsigned PAIRS = STAGES - 1;

    logic [STAGES-1:0] state_q;
    logic [PAIRS-1:0]  bnd;
    logic              shin;

    // A valid twisted-ring code has at most one boundary between
    // neighbouring bits.
    for (genvar i = 0; i < PAIRS; i++) begin : g_bnd
        assign bnd[i] = state_q[i] ^ state_q[i+1];
    end

    assign legal_o = $onehot0(bnd);

    // Anti-lock: zeros are shifted in until the code becomes valid (R8)
    assign shin = legal_o ? ~state_q[STAGES-1] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (adv) begin
            state_q <= {state_q[STAGES-2:0], shin};
        end
    end

    assign ring_o = state_q;

endmodule

// File: rtl/jdc_decode.sv
`timescale 1ns/1ps
module jdc_decode #(
    parameter int unsigned STAGES = jdc_pkg::DEF_STAGES,
    localparam int unsigned COUNTS = 2 * STAGES
) (
    input  logic [STAGES-1:0] ring,
    output logic [COUNTS-1:0] dec_o,
    output logic              carry_o
);

    // Count 0 is all zeros, count STAGES is all ones
    assign dec_o[0]      = ~ring[STAGES-1] & ~ring[0];
    assign dec_o[STAGES] =  ring[STAGES-1] &  ring[0];

    // Filling phase: boundary 1->0 between bits k-1 and k.
    // Draining phase: boundary 0->1 at the same place.
    for (genvar k = 1; k < STAGES; k++) begin : g_dec
        assign dec_o[k]        =  ring[k-1] & ~ring[k];
        assign dec_o[k+STAGES] = ~ring[k-1] &  ring[k];
    end

    assign carry_o = ~ring[STAGES-1];

endmodule

// File: rtl/johnson_decade.sv
`timescale 1ns/1ps
module johnson_decade #(
    parameter int unsigned STAGES = jdc_pkg::DEF_STAGES,
    localparam int unsigned COUNTS = 2 * STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_clk,
    input  logic              cnt_inh,
    output logic [COUNTS-1:0] dec_o,
    output logic              carry_o
);

    logic              adv;
    logic              ring_legal;
    logic [STAGES-1:0] ring_q;

    jdc_edge_sense u_sense (
        .clk     (clk),
        .rst     (rst),
        .cnt_clk (cnt_clk),
        .cnt_inh (cnt_inh),
        .adv     (adv)
    );

    jdc_ring #(.STAGES(STAGES)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .ring_o  (ring_q),
        .legal_o (ring_legal)
    );

    jdc_decode #(.STAGES(STAGES)) u_dec (
        .ring    (ring_q),
        .dec_o   (dec_o),
        .carry_o (carry_o)
    );

endmodule

// File: rtl/jdc_checker.sv
`timescale 1ns/1ps
module jdc_checker #(
    parameter int unsigned STAGES = jdc_pkg::DEF_STAGES,
    localparam int unsigned COUNTS = 2 * STAGES
) (
    input logic              clk,
    input logic              rst,
    input logic              adv,
    input logic              legal,
    input logic [STAGES-1:0] ring,
    input logic [COUNTS-1:0] dec_o,
    input logic              carry_o
);

    logic rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
    end

    // R1: a clock edge with reset high leaves count zero
    always @(negedge clk) begin
        if (rst_q === 1'b1) begin
            p_reset_zero_r1: assert (dec_o == COUNTS'(1) && carry_o == 1'b1);
        end
    end

    // R2: an advance from a valid code rotates the one-hot output by one
    p_step_rotates_r2: assert property (@(posedge clk) disable iff (rst)
        (adv && legal) |=> dec_o == {$past(dec_o[COUNTS-2:0]), $past(dec_o[COUNTS-1])});

    // R6: a valid code decodes to exactly one active output
    p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        legal |-> $onehot(dec_o));

    // R7: carry is high exactly in the lower half of the range
    p_carry_half_r7: assert property (@(posedge clk) disable iff (rst)
        legal |-> (carry_o == (|dec_o[STAGES-1:0])));

    // R8: an advance from an invalid code shifts in a zero
    p_recover_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (adv && !legal) |=> (ring[0] == 1'b0));

endmodule

bind johnson_decade jdc_checker #(.STAGES(STAGES)) u_jdc_chk (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .legal   (ring_legal),
    .ring    (ring_q),
    .dec_o   (dec_o),
    .carry_o (carry_o)
);

// File: tb/test_johnson_decade.sv
`timescale 1ns/1ps
module test_johnson_decade;

    localparam int S = 5;
    localparam int N = 2 * S;

    logic         clk = 1'b0;
    logic         rst;
    logic         cnt_clk;
    logic         cnt_inh;
    logic [N-1:0] dec_o;
    logic         carry_o;

    typedef struct {
        string        tag;
        logic [N-1:0] dec;
        logic         carry;
    } exp_t;

    exp_t         exp_q[$];
    event         ev_sample;
    int           checks = 0;
    int           errors = 0;
    logic [S-1:0] ring_m;

    always #10 clk = ~clk;

    johnson_decade #(.STAGES(S)) i_johnson_decade (
        .clk     (clk),
        .rst     (rst),
        .cnt_clk (cnt_clk),
        .cnt_inh (cnt_inh),
        .dec_o   (dec_o),
        .carry_o (carry_o)
    );

    // Valid code for count k, as listed in R6
    function automatic logic [S-1:0] seq_code(int k);
        int v;
        if (k <= S) v = (1 << k) - 1;
        else        v = ((1 << S) - 1) & ~((1 << (k - S)) - 1);
        return v[S-1:0];
    endfunction

    function automatic int code_index(logic [S-1:0] code);
        for (int k = 0; k < N; k++) if (seq_code(k) == code) return k;
        return -1;
    endfunction

    // R6 / R8: the bit shifted in is ~MSB for a valid code, else 0
    task automatic step_model();
        logic shin;
        shin = (code_index(ring_m) >= 0) ? ~ring_m[S-1] : 1'b0;
        ring_m = {ring_m[S-2:0], shin};
    endtask

    task automatic check_int(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver side: push the expected outputs, let the monitor compare
    task automatic expect_now(string tag);
        exp_t it;
        int   idx;
        idx      = code_index(ring_m);
        it.tag   = tag;
        it.dec   = N'(1) << idx;
        it.carry = (idx < S);
        exp_q.push_back(it);
        -> ev_sample;
        wait (exp_q.size() == 0);
    endtask

    // Monitor: compare each expected item with the live outputs
    initial begin
        forever begin
            exp_t it;
            @(ev_sample);
            it = exp_q.pop_front();
            checks++;
            if (dec_o !== it.dec || carry_o !== it.carry) begin
                errors++;
                $display("FAIL %s dec=%b carry=%b expected dec=%b carry=%b",
                         it.tag, dec_o, carry_o, it.dec, it.carry);
            end
        end
    end

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // One count-clock pulse with the latency check of R2
    task automatic pulse(string tag);
        @(negedge clk) cnt_clk = 1'b1;
        @(negedge clk);
        expect_now({tag, " one edge after rise, not yet moved"});
        @(negedge clk);
        if (!cnt_inh) step_model();
        expect_now({tag, " two edges after rise"});
        @(negedge clk) cnt_clk = 1'b0;
        settle();
        expect_now("R5 falling count clock has no effect");
    endtask

    task automatic run_all();
        int illegal;
        rst = 1'b1; cnt_clk = 1'b0; cnt_inh = 1'b0; ring_m = '0;
        repeat (4) @(negedge clk);
        expect_now("R1 reset held");
        rst = 1'b0;
        settle();
        expect_now("R1 idle after release");

        // Twelve pulses: wrap and both carry boundaries (R2 R6 R7)
        for (int i = 0; i < 12; i++) pulse("R2 R6 R7");

        // R3: inhibit blocks rising edges
        @(negedge clk) cnt_inh = 1'b1;
        settle();
        expect_now("R5 inhibit rise has no effect");
        for (int i = 0; i < 3; i++) pulse("R3 inhibited");

        // R4: inhibit falls while count clock high
        @(negedge clk) cnt_clk = 1'b1;
        settle();
        expect_now("R3 rise under inhibit");
        @(negedge clk) cnt_inh = 1'b0;
        settle();
        step_model();
        expect_now("R4 inhibit fall with clock high");
        @(negedge clk) cnt_inh = 1'b1;
        settle();
        expect_now("R5 inhibit rise with clock high");
        @(negedge clk) cnt_clk = 1'b0;
        settle();
        @(negedge clk) cnt_inh = 1'b0;
        settle();
        expect_now("R5 inhibit fall with clock low");

        // R1: reset overrides counting mid-sequence
        for (int i = 0; i < 3; i++) pulse("R2");
        @(negedge clk) begin rst = 1'b1; cnt_clk = 1'b1; end
        @(negedge clk) cnt_clk = 1'b0;
        @(negedge clk) cnt_clk = 1'b1;
        @(negedge clk);
        ring_m = '0;
        expect_now("R1 reset over count activity");

        // R9: level changed during reset is not an edge afterwards
        @(negedge clk) rst = 1'b0;
        settle();
        expect_now("R9 no advance after release");
        @(negedge clk) cnt_clk = 1'b0;
        settle();
        expect_now("R9 count clock drop after release");

        // R8: every invalid code returns to the sequence
        illegal = 0;
        for (int c = 0; c < (1 << S); c++) begin
            if (code_index(c[S-1:0]) < 0) begin
                illegal++;
                @(negedge clk);
                i_johnson_decade.u_ring.state_q = c[S-1:0];
                ring_m = c[S-1:0];
                for (int p = 0; p < S - 1; p++) begin
                    @(negedge clk) cnt_clk = 1'b1;
                    settle();
                    step_model();
                    if (code_index(ring_m) >= 0) expect_now("R8 recovered code");
                    @(negedge clk) cnt_clk = 1'b0;
                    settle();
                end
                check_int("R8 valid within STAGES-1 advances",
                          int'(code_index(ring_m) >= 0), 1);
                pulse("R8 normal count after recovery");
            end
        end
        check_int("R8 number of invalid codes", illegal, 22);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule